// File: doc/BRIEF.md
# Local Interrupt Acceptance and Delivery Selector

This block takes interrupt requests aimed at one processor core and keeps them until the core takes them. Each request carries an 8-bit vector, a 3-bit delivery mode and a level/edge flag. Fixed and lowest-priority requests are vectored. They set one bit, picked by the vector, in a 256-bit request bitmap. A companion 256-bit trigger bitmap records whether each such vector arrived level-sensitive or edge-sensitive.

System-class requests do not use the bitmap. These are SMI, NMI, INIT and external interrupts. Each class has its own single-entry latch that holds a pending flag and a captured vector. While a latch is pending, a further request of that class is dropped.

A combinational selector presents the next interrupt to deliver, in a fixed order of precedence. The core's acknowledge clears whatever is being presented at that moment. A register also tracks the highest vectored request seen so far.

Top module: `irq_accept`

## Requirements
- R1: A request with mode 0 (fixed) or 1 (lowest priority) sets the bitmap bit of its vector. The word index is vector[7:5] and the bit index is vector[4:0]. With no system-class latch pending, the highest set vector is delivered with dlv_kind_o = 0.
- R2: The trigger bit of a vector is written on a vectored request only when that vector's request bit was clear beforehand: 1 for level (req_level_i = 1), 0 for edge. A repeat request leaves the bit unchanged. dlv_level_o shows the trigger bit of the delivered vector.
- R3: irr_max_o resets to 0. It takes the vector of a vectored request whenever that vector is greater than its current value, and it never decreases.
- R4: Requests with mode 2 (SMI), 4 (NMI), 5 (INIT) or 7 (external) set their class's pending latch and capture its vector only if that latch is clear. A later request of the same class while pending is dropped.
- R5: unmask_pend_o is 1 while an SMI, NMI or INIT is pending, is not raised by an external request, and falls once none of those three is pending.
- R6: Requests with mode 3 or 6 are reserved and change no state or output.
- R7: Delivery order is SMI, then NMI, then INIT, then external, then the vectored bitmap. dlv_kind_o carries the mode code of the class delivered.
- R8: ack_i clears the latch, or the bitmap bit, that is being delivered in that cycle. The trigger bitmap is kept. An acknowledge with nothing valid has no effect.
- R9: After reset nothing is pending: dlv_valid_o = 0, unmask_pend_o = 0 and irr_max_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one per cycle |
| req_vector_i | input | 8 | Request vector |
| req_mode_i | input | 3 | Delivery mode code |
| req_level_i | input | 1 | 1 level, 0 edge |
| ack_i | input | 1 | Core takes the delivered interrupt |
| dlv_valid_o | output | 1 | An interrupt is presented |
| dlv_kind_o | output | 3 | Mode code of the presented class (0 for the bitmap) |
| dlv_vector_o | output | 8 | Vector of the presented interrupt |
| dlv_level_o | output | 1 | Trigger bit of the presented vectored interrupt |
| unmask_pend_o | output | 1 | SMI, NMI or INIT pending |
| irr_max_o | output | 8 | Highest vectored request seen |

## Verification
Vectored requests are applied in several patterns:
- in descending and ascending order, which shows whether the highest vector is picked;
- on either side of a 32-bit word boundary and at vectors 0 and 255, which exposes errors in word and bit indexing;
- as a repeat request with the opposite level flag, which shows whether the first-request-only rule for the trigger bit holds.

System-class requests are raised from lowest to highest precedence and then acknowledged one by one. This shows the fixed order. It also shows whether the summary flag stays clear with only an external interrupt pending, and whether it falls when the INIT latch is cleared.

A second SMI sent while one is pending must not replace the held vector. A later SMI sent after the latch has cleared must be captured. Together these two cases separate the first-request-wins rule from plain overwrite behaviour.

Reserved codes are sent with a pending SMI in place. They must leave every output unchanged.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  parameter int VEC_W  = 8;
  parameter int WORD_W = 32;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int NUM_SYS = 4;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSV3   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_RSV6   = 3'd6,
    DM_EXT    = 3'd7
  } dmode_e;

  // latch slot k in precedence order
  function automatic dmode_e sys_code(int k);
    case (k)
      0:       return DM_SMI;
      1:       return DM_NMI;
      2:       return DM_INIT;
      default: return DM_EXT;
    endcase
  endfunction
endpackage

// File: rtl/irq_vec_bitmap.sv
module irq_vec_bitmap #(
  parameter int VEC_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   set_i,
  input  logic [VEC_W-1:0]       set_vec_i,
  input  logic                   set_level_i,
  input  logic                   clr_i,
  input  logic [VEC_W-1:0]       clr_vec_i,
  output logic [(1<<VEC_W)-1:0]  req_o,
  output logic [(1<<VEC_W)-1:0]  trig_o
);
  localparam int NUM_VEC   = 1 << VEC_W;
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int WIDX_W    = VEC_W - BIT_W;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] req_q, trig_q, set_mask, clr_mask, fresh;

    always_comb begin
      set_mask = '0;
      clr_mask = '0;
      if (set_i && set_vec_i[VEC_W-1:BIT_W] == WIDX_W'(w))
        set_mask[set_vec_i[BIT_W-1:0]] = 1'b1;
      if (clr_i && clr_vec_i[VEC_W-1:BIT_W] == WIDX_W'(w))
        clr_mask[clr_vec_i[BIT_W-1:0]] = 1'b1;
      fresh = set_mask & ~req_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q  <= '0;
        trig_q <= '0;
      end else begin
        req_q  <= (req_q & ~clr_mask) | set_mask;
        trig_q <= (trig_q & ~fresh) | (fresh & {WORD_W{set_level_i}});
      end
    end

    assign req_o[w*WORD_W +: WORD_W]  = req_q;
    assign trig_o[w*WORD_W +: WORD_W] = trig_q;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int VEC_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic [(1<<VEC_W)-1:0] bits_i,
  output logic                  any_o,
  output logic [VEC_W-1:0]      idx_o
);
  localparam int NUM_VEC   = 1 << VEC_W;
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int WIDX_W    = VEC_W - BIT_W;

  logic [NUM_WORDS-1:0] w_any;
  logic [BIT_W-1:0]     w_hi [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_comb begin
      w_any[w] = 1'b0;
      w_hi[w]  = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (bits_i[w*WORD_W+b]) begin
          w_any[w] = 1'b1;
          w_hi[w]  = BIT_W'(b);
        end
      end
    end
  end

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (w_any[w]) begin
        any_o = 1'b1;
        idx_o = {WIDX_W'(w), w_hi[w]};
      end
    end
  end
endmodule

// File: rtl/irq_sys_latch.sv
module irq_sys_latch #(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             clr_i,
  output logic             pend_o,
  output logic [VEC_W-1:0] vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      vec_o  <= '0;
    end else if (set_i && !pend_o) begin
      pend_o <= 1'b1;
      vec_o  <= vec_i;
    end else if (clr_i) begin
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_accept_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int WW = WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [VW-1:0] req_vector_i,
  input  logic [2:0]    req_mode_i,
  input  logic          req_level_i,
  input  logic          ack_i,
  output logic          dlv_valid_o,
  output logic [2:0]    dlv_kind_o,
  output logic [VW-1:0] dlv_vector_o,
  output logic          dlv_level_o,
  output logic          unmask_pend_o,
  output logic [VW-1:0] irr_max_o
);
  localparam int NV = 1 << VW;

  logic          vec_req;
  logic [NV-1:0] req_bits, trig_bits;
  logic          pick_any;
  logic [VW-1:0] pick_idx;
  logic [NUM_SYS-1:0] sys_pend, sys_clr;
  logic [VW-1:0] sys_vec [NUM_SYS];
  logic          sel_sys;
  logic [1:0]    sel_k;
  logic          bm_clr;

  assign vec_req = req_valid_i &&
                   (req_mode_i == DM_FIXED || req_mode_i == DM_LOWEST);

  irq_vec_bitmap #(.VEC_W(VW), .WORD_W(WW)) u_bitmap (
    .clk_i, .rst_ni,
    .set_i(vec_req), .set_vec_i(req_vector_i), .set_level_i(req_level_i),
    .clr_i(bm_clr), .clr_vec_i(pick_idx),
    .req_o(req_bits), .trig_o(trig_bits)
  );

  irq_prio_pick #(.VEC_W(VW), .WORD_W(WW)) u_pick (
    .bits_i(req_bits), .any_o(pick_any), .idx_o(pick_idx)
  );

  for (genvar k = 0; k < NUM_SYS; k++) begin : g_sys
    localparam dmode_e CODE = sys_code(k);
    logic set_k;
    assign set_k = req_valid_i && req_mode_i == CODE;
    irq_sys_latch #(.VEC_W(VW)) u_latch (
      .clk_i, .rst_ni,
      .set_i(set_k), .vec_i(req_vector_i), .clr_i(sys_clr[k]),
      .pend_o(sys_pend[k]), .vec_o(sys_vec[k])
    );
  end

  // lowest slot index has precedence
  always_comb begin
    sel_sys = 1'b0;
    sel_k   = '0;
    for (int k = NUM_SYS - 1; k >= 0; k--) begin
      if (sys_pend[k]) begin
        sel_sys = 1'b1;
        sel_k   = 2'(k);
      end
    end
  end

  always_comb begin
    sys_clr = '0;
    if (ack_i && sel_sys) sys_clr[sel_k] = 1'b1;
  end
  assign bm_clr = ack_i && !sel_sys && pick_any;

  always_comb begin
    dlv_valid_o  = sel_sys || pick_any;
    dlv_kind_o   = DM_FIXED;
    dlv_vector_o = pick_idx;
    dlv_level_o  = 1'b0;
    if (sel_sys) begin
      dlv_kind_o   = sys_code(int'(sel_k));
      dlv_vector_o = sys_vec[sel_k];
    end else if (pick_any) begin
      dlv_level_o  = trig_bits[pick_idx];
    end
  end

  assign unmask_pend_o = |sys_pend[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                irr_max_o <= '0;
    else if (vec_req && req_vector_i > irr_max_o) irr_max_o <= req_vector_i;
  end
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int VW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [VW-1:0] req_vector_i,
  input logic [2:0]    req_mode_i,
  input logic          req_level_i,
  input logic          ack_i,
  input logic          dlv_valid_o,
  input logic [2:0]    dlv_kind_o,
  input logic [VW-1:0] dlv_vector_o,
  input logic          dlv_level_o,
  input logic          unmask_pend_o,
  input logic [VW-1:0] irr_max_o
);
  logic rsv_req;
  assign rsv_req = req_valid_i && (req_mode_i == 3'd3 || req_mode_i == 3'd6);

  assert_max_mono_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irr_max_o >= $past(irr_max_o));

  assert_rsv_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_req && !ack_i |=> $stable(dlv_valid_o) && $stable(dlv_vector_o) &&
                          $stable(dlv_kind_o) && $stable(irr_max_o) &&
                          $stable(unmask_pend_o));

  assert_unmask_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmask_pend_o |-> dlv_valid_o && dlv_kind_o != 3'd7 && dlv_kind_o != 3'd0);

  assert_smi_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o && dlv_kind_o == 3'd2 && req_valid_i && req_mode_i == 3'd2 &&
    !ack_i |=> dlv_kind_o == 3'd2 && $stable(dlv_vector_o));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i && !req_valid_i |=> $stable(dlv_valid_o) && $stable(dlv_vector_o) &&
                               $stable(dlv_kind_o) && $stable(dlv_level_o));

  // req_vector_i and req_level_i appear only through the bound port list
  logic unused_ok;
  assign unused_ok = ^{req_vector_i, req_level_i};
endmodule

bind irq_accept irq_accept_chk #(.VW(VW)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_vector_i, .req_mode_i, .req_level_i,
  .ack_i, .dlv_valid_o, .dlv_kind_o, .dlv_vector_o, .dlv_level_o,
  .unmask_pend_o, .irr_max_o
);

// File: tb/irq_accept_test.sv
module irq_accept_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [7:0] req_vector_i = '0;
  logic [2:0] req_mode_i = '0;
  logic       req_level_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       dlv_valid_o;
  logic [2:0] dlv_kind_o;
  logic [7:0] dlv_vector_o;
  logic       dlv_level_o;
  logic       unmask_pend_o;
  logic [7:0] irr_max_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  irq_accept uut (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic req(logic [7:0] v, logic [2:0] m, logic l);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vector_i = v; req_mode_i = m; req_level_i = l;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk_i);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic expect_dlv(string tag, int kind, int vec);
    chk({tag, " valid"}, dlv_valid_o, 1);
    chk({tag, " kind"}, dlv_kind_o, kind);
    chk({tag, " vector"}, dlv_vector_o, vec);
  endtask

  task automatic t_reset();
    chk("R9 valid", dlv_valid_o, 0);
    chk("R9 unmask", unmask_pend_o, 0);
    chk("R9 irr_max", irr_max_o, 0);
    ack();
    chk("R8 idle ack", dlv_valid_o, 0);
  endtask

  task automatic t_vectored();
    req(8'h40, 3'd0, 1'b0);
    expect_dlv("R1 first", 0, 8'h40);
    chk("R2 edge", dlv_level_o, 0);
    chk("R3 raise", irr_max_o, 8'h40);
    req(8'h23, 3'd1, 1'b1);
    expect_dlv("R1 highest kept", 0, 8'h40);
    chk("R3 no lower", irr_max_o, 8'h40);
    ack();
    expect_dlv("R8 next", 0, 8'h23);
    chk("R2 level", dlv_level_o, 1);
    ack();
    chk("R8 empty", dlv_valid_o, 0);
    chk("R3 never falls", irr_max_o, 8'h40);
    // word boundary, ascending arrival
    req(8'h1F, 3'd0, 1'b0);
    req(8'h20, 3'd0, 1'b1);
    expect_dlv("R1 boundary hi", 0, 8'h20);
    ack();
    expect_dlv("R1 boundary lo", 0, 8'h1F);
    ack();
    req(8'h00, 3'd0, 1'b1);
    expect_dlv("R1 vector 0", 0, 8'h00);
    req(8'hFF, 3'd1, 1'b0);
    expect_dlv("R1 vector 255", 0, 8'hFF);
    chk("R3 top", irr_max_o, 8'hFF);
    ack();
    expect_dlv("R1 back to 0", 0, 8'h00);
    chk("R2 level v0", dlv_level_o, 1);
    ack();
  endtask

  task automatic t_trigger();
    req(8'h81, 3'd0, 1'b1);
    chk("R2 fresh level", dlv_level_o, 1);
    req(8'h81, 3'd0, 1'b0);
    chk("R2 repeat keeps", dlv_level_o, 1);
    ack();
    chk("R8 single clear", dlv_valid_o, 0);
    req(8'h81, 3'd1, 1'b0);
    chk("R2 rewritten edge", dlv_level_o, 0);
    ack();
  endtask

  task automatic t_reserved();
    req(8'h10, 3'd3, 1'b0);
    req(8'h11, 3'd6, 1'b1);
    chk("R6 no valid", dlv_valid_o, 0);
    chk("R6 no unmask", unmask_pend_o, 0);
    chk("R6 irr_max", irr_max_o, 8'hFF);
  endtask

  task automatic t_system();
    req(8'h90, 3'd0, 1'b0);
    req(8'h30, 3'd7, 1'b0);
    expect_dlv("R7 ext over bitmap", 7, 8'h30);
    chk("R5 ext not unmask", unmask_pend_o, 0);
    req(8'h31, 3'd5, 1'b0);
    expect_dlv("R7 init over ext", 5, 8'h31);
    chk("R5 init unmask", unmask_pend_o, 1);
    req(8'h32, 3'd4, 1'b0);
    expect_dlv("R7 nmi over init", 4, 8'h32);
    req(8'h33, 3'd2, 1'b0);
    expect_dlv("R7 smi first", 2, 8'h33);
    req(8'h55, 3'd2, 1'b0);
    expect_dlv("R4 smi dropped", 2, 8'h33);
    req(8'h66, 3'd3, 1'b0);
    expect_dlv("R6 rsv under smi", 2, 8'h33);
    ack();
    expect_dlv("R8 to nmi", 4, 8'h32);
    ack();
    expect_dlv("R8 to init", 5, 8'h31);
    chk("R5 still unmask", unmask_pend_o, 1);
    ack();
    expect_dlv("R8 to ext", 7, 8'h30);
    chk("R5 unmask drops", unmask_pend_o, 0);
    ack();
    expect_dlv("R8 to bitmap", 0, 8'h90);
    ack();
    chk("R8 all clear", dlv_valid_o, 0);
    req(8'h55, 3'd2, 1'b0);
    expect_dlv("R4 rearmed", 2, 8'h55);
    ack();
    chk("R5 final", unmask_pend_o, 0);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_vectored();
    t_trigger();
    t_reserved();
    t_system();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule